// File: doc/BRIEF.md
# Three-Way Intersection Light Controller

This block decides when north-bound, south-bound and east-bound traffic may proceed at a three-way crossing. Each approach has a car-present sensor input and a go output. A sensor pulse is remembered as a pending request for that approach. Outputs are registered, so they change on the clock edge after the decision is made. The block has no yellow phase and no timer. A green light stays green while its sensor reports a car, and it drops once the sensor goes low.

North and south may be green at the same time. They share an internal hold flag that keeps east red while either of them is green. A pending east request blocks any new north or south start, so east gets the crossing once the north/south pair has drained. Two cases need care. The first is south turning off at the same moment north turns on. The second is both turning off together. In both cases the hold flag must end up correct: it must not be dropped under a live north light, and it must not stay stuck with no light on.

Top module: `xing_light_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, all go outputs, all pending requests and the hold flag are 0.
- R2: A sensor that is high at one clock edge leaves that approach's request pending until the approach is served. A one-cycle pulse that arrives while the approach is blocked is still served later, with no further sensor activity.
- R3: If north has a pending request, north is off and no east request is pending, `go_n` rises at the next edge. This is two edges after the sensor first goes high when nothing blocks it.
- R4: If north is green and `sense_n` is low at an edge, `go_n` falls at that edge and north's request is cleared. Clearing wins over a sensor set in the same update, and north does not come on again without a new sensor event.
- R5: South follows the rules of R3 and R4 with `sense_s` and `go_s`.
- R6: East turns on at the next edge when its request is pending, the hold flag is clear and east is off. While an east request is pending, neither north nor south may start.
- R7: If east is green and `sense_e` is low at an edge, `go_e` falls and east's request is cleared.
- R8: `go_e` is never high in the same cycle as `go_n` or `go_s`.
- R9: When north and south turn off at the same edge, the hold flag is released, and a pending east request turns east on at the following edge.
- R10: When south turns off at the same edge as north turns on, the hold flag stays set, and east stays red until north turns off.
- R11: The hold flag is set in every cycle in which north or south is green.
- R12: When every car leaves within a few cycles of getting green, every approach whose sensor is high is served within a bounded number of cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sense_n | input | 1 | Car present on the north approach |
| sense_s | input | 1 | Car present on the south approach |
| sense_e | input | 1 | Car present on the east approach |
| go_n | output | 1 | North may proceed |
| go_s | output | 1 | South may proceed |
| go_e | output | 1 | East may proceed |

## Verification
A sensor level is latched at the edge where it is first seen, and the go output it causes rises at the next edge. A first start therefore shows two edges after the sensor rises, while a stop shows at the same edge where the sensor is seen low. The bench drives inputs on the falling edge and samples outputs one time unit after each rising edge. Every expected value is tied to the state after exactly that edge. The two race sequences are set up so that a wrong hold flag shows up as an east light at a known sampled cycle, or as one that never comes on.

// File: rtl/xing_pkg.sv
package xing_pkg;
    localparam int NDIR  = 3;
    localparam int IDX_N = 0;
    localparam int IDX_S = 1;
    localparam int IDX_E = 2;

    typedef struct packed {
        logic [NDIR-1:0] req;
        logic [NDIR-1:0] go;
        logic            hold;
    } xing_state_t;
endpackage

// File: rtl/xing_req_latch.sv
module xing_req_latch (
    input  logic req_q,
    input  logic sense,
    input  logic clr,
    output logic req_d
);
    // clearing on stop wins over a sensor set in the same update
    always_comb begin
        req_d = req_q | sense;
        if (clr) req_d = 1'b0;
    end
endmodule

// File: rtl/xing_arm.sv
module xing_arm (
    input  logic req_q,
    input  logic go_q,
    input  logic sense,
    input  logic blocked,
    output logic start,
    output logic stop
);
    always_comb begin
        start = req_q & ~go_q & ~blocked;
        stop  = go_q & ~sense;
    end
endmodule

// File: rtl/xing_hold_ctl.sv
module xing_hold_ctl (
    input  logic hold_q,
    input  logic n_start,
    input  logic n_stop,
    input  logic s_start,
    input  logic s_stop,
    input  logic go_n_q,
    input  logic go_s_q,
    input  logic sense_s,
    output logic hold_d
);
    always_comb begin
        hold_d = hold_q;
        // north side: release also when south is dropping in the same update
        if (n_start)
            hold_d = 1'b1;
        else if (n_stop && (!go_s_q || !sense_s))
            hold_d = 1'b0;
        // south side overrides: never release under a live or starting north
        if (s_start)
            hold_d = 1'b1;
        else if (s_stop && !(go_n_q || n_start))
            hold_d = 1'b0;
    end
endmodule

// File: rtl/xing_light_ctrl.sv
module xing_light_ctrl
    import xing_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sense_n,
    input  logic sense_s,
    input  logic sense_e,
    output logic go_n,
    output logic go_s,
    output logic go_e
);
    xing_state_t state_d, state_q;

    logic [NDIR-1:0] sense_v;
    logic [NDIR-1:0] start_w;
    logic [NDIR-1:0] stop_w;
    logic [NDIR-1:0] req_nx;
    logic            hold_nx;

    // views for the bound checker
    logic [NDIR-1:0] req_view;
    logic            hold_view;

    always_comb begin
        sense_v        = '0;
        sense_v[IDX_N] = sense_n;
        sense_v[IDX_S] = sense_s;
        sense_v[IDX_E] = sense_e;
    end

    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        logic blk;
        if (d == IDX_E) begin : g_cross
            assign blk = state_q.hold;
        end else begin : g_pair
            assign blk = state_q.req[IDX_E];
        end

        xing_arm u_arm (
            .req_q   (state_q.req[d]),
            .go_q    (state_q.go[d]),
            .sense   (sense_v[d]),
            .blocked (blk),
            .start   (start_w[d]),
            .stop    (stop_w[d])
        );

        xing_req_latch u_req (
            .req_q (state_q.req[d]),
            .sense (sense_v[d]),
            .clr   (stop_w[d]),
            .req_d (req_nx[d])
        );
    end

    xing_hold_ctl u_hold (
        .hold_q  (state_q.hold),
        .n_start (start_w[IDX_N]),
        .n_stop  (stop_w[IDX_N]),
        .s_start (start_w[IDX_S]),
        .s_stop  (stop_w[IDX_S]),
        .go_n_q  (state_q.go[IDX_N]),
        .go_s_q  (state_q.go[IDX_S]),
        .sense_s (sense_s),
        .hold_d  (hold_nx)
    );

    always_comb begin
        state_d      = state_q;
        state_d.req  = req_nx;
        state_d.go   = (state_q.go | start_w) & ~stop_w;
        state_d.hold = hold_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign go_n      = state_q.go[IDX_N];
    assign go_s      = state_q.go[IDX_S];
    assign go_e      = state_q.go[IDX_E];
    assign req_view  = state_q.req;
    assign hold_view = state_q.hold;
endmodule

// File: rtl/xing_light_ctrl_chk.sv
module xing_light_ctrl_chk
    import xing_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            sense_n,
    input logic            sense_s,
    input logic            sense_e,
    input logic            go_n,
    input logic            go_s,
    input logic            go_e,
    input logic [NDIR-1:0] req,
    input logic            hold
);
    a_r8_cross_safe: assert property (@(posedge clk) disable iff (!rst_n)
        !(go_e && (go_n || go_s)));

    a_r11_hold_covers: assert property (@(posedge clk) disable iff (!rst_n)
        (go_n || go_s) |-> hold);

    a_r3_north_start: assert property (@(posedge clk) disable iff (!rst_n)
        (req[IDX_N] && !go_n && !req[IDX_E]) |=> go_n);

    a_r4_north_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (go_n && !sense_n) |=> (!go_n && !req[IDX_N]));

    a_r5_south_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (go_s && !sense_s) |=> (!go_s && !req[IDX_S]));

    a_r6_east_start: assert property (@(posedge clk) disable iff (!rst_n)
        (req[IDX_E] && !hold && !go_e) |=> go_e);

    a_r7_east_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (go_e && !sense_e) |=> (!go_e && !req[IDX_E]));

    a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req[IDX_N] && !(go_n && !sense_n)) |=> req[IDX_N]);

    a_r6_east_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (req[IDX_E] && !go_n) |=> !go_n);
endmodule

bind xing_light_ctrl xing_light_ctrl_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sense_n (sense_n),
    .sense_s (sense_s),
    .sense_e (sense_e),
    .go_n    (go_n),
    .go_s    (go_s),
    .go_e    (go_e),
    .req     (req_view),
    .hold    (hold_view)
);

// File: tb/tb_xing_light_ctrl.sv
module tb_xing_light_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 14;
    localparam int RAND_CYC   = 3000;
    localparam int WAIT_MAX   = 150;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sense_n = 1'b0, sense_s = 1'b0, sense_e = 1'b0;
    logic go_n, go_s, go_e;
    int errors = 0;
    int checks = 0;

    // entry = {sense_n, sense_s, sense_e, exp go_n, exp go_s, exp go_e}
    localparam logic [5:0] VEC [NVEC] = '{
        6'b100_000,  // R2 north sensed, latched
        6'b100_100,  // R3 north on
        6'b101_100,  // east sensed while north green
        6'b001_000,  // R4 north off, hold released
        6'b001_001,  // R6 east on
        6'b011_001,  // south sensed
        6'b011_001,  // R6 pending east blocks south start
        6'b010_000,  // R7 east off
        6'b010_010,  // R5 south on
        6'b110_010,  // north sensed
        6'b110_110,  // R3 north joins south
        6'b100_100,  // R5 south off, north stays
        6'b000_000,  // R4 north off
        6'b000_000   // R4 no restart without new sensor
    };

    xing_light_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .sense_n(sense_n), .sense_s(sense_s), .sense_e(sense_e),
        .go_n(go_n), .go_s(go_s), .go_e(go_e)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check_go(input logic [2:0] exp, input string tag);
        checks++;
        if ({go_n, go_s, go_e} !== exp) begin
            errors++;
            $display("FAIL %s: go(n,s,e) actual=%b expected=%b at %0t",
                     tag, {go_n, go_s, go_e}, exp, $time);
        end
    endtask

    // drive on falling edge, sample 1 unit after the rising edge
    task automatic step(input logic [2:0] s, input logic [2:0] exp, input string tag);
        @(negedge clk);
        {sense_n, sense_s, sense_e} = s;
        @(posedge clk);
        #1;
        check_go(exp, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        {sense_n, sense_s, sense_e} = 3'b000;
        @(posedge clk); @(posedge clk);
        #1;
        check_go(3'b000, "R1");
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        do_reset();
        // R1: first cycle after release
        step(3'b000, 3'b000, "R1");

        for (int i = 0; i < NVEC; i++)
            step(VEC[i][5:3], VEC[i][2:0], $sformatf("R3-R7 vector %0d", i));

        // R10: south drops exactly as north starts; hold must survive
        do_reset();
        step(3'b010, 3'b000, "R5");
        step(3'b010, 3'b010, "R5");
        step(3'b110, 3'b010, "R10");
        step(3'b100, 3'b100, "R10");
        step(3'b101, 3'b100, "R10");
        step(3'b101, 3'b100, "R10");
        step(3'b001, 3'b000, "R10");
        step(3'b001, 3'b001, "R10");
        step(3'b000, 3'b000, "R7");

        // R9: both drop together; hold must be freed for east
        do_reset();
        step(3'b110, 3'b000, "R9");
        step(3'b110, 3'b110, "R9");
        step(3'b111, 3'b110, "R9");
        step(3'b001, 3'b000, "R9");
        step(3'b001, 3'b001, "R9");

        // R2: one-cycle north pulse while east holds the crossing
        do_reset();
        step(3'b001, 3'b000, "R2");
        step(3'b001, 3'b001, "R2");
        step(3'b101, 3'b001, "R2");
        step(3'b001, 3'b001, "R2");
        step(3'b000, 3'b000, "R2");
        step(3'b000, 3'b100, "R2");
        step(3'b000, 3'b000, "R2");

        // R1: reset in the middle of activity
        step(3'b110, 3'b000, "R1");
        step(3'b110, 3'b110, "R1");
        do_reset();

        // R12 / R8: random arrivals, cars leave a few cycles after green
        begin
            int present [3];
            int leave   [3];
            int cool    [3];
            int waitc   [3];
            logic [2:0] g;
            for (int d = 0; d < 3; d++) begin
                present[d] = 0; leave[d] = 0; cool[d] = 0; waitc[d] = 0;
            end
            for (int c = 0; c < RAND_CYC; c++) begin
                @(negedge clk);
                g = {go_n, go_s, go_e};
                for (int d = 0; d < 3; d++) begin
                    if (present[d] == 0) begin
                        if (cool[d] > 0) cool[d]--;
                        else if (($urandom % 8) == 0) begin
                            present[d] = 1;
                            leave[d] = 1 + int'($urandom % 3);
                        end
                    end else if (g[2-d]) begin
                        if (leave[d] > 0) leave[d]--;
                        else begin
                            present[d] = 0;
                            cool[d] = 2;
                        end
                    end
                end
                sense_n = present[0] != 0;
                sense_s = present[1] != 0;
                sense_e = present[2] != 0;
                @(posedge clk);
                #1;
                checks++;
                if (go_e && (go_n || go_s)) begin
                    errors++;
                    $display("FAIL R8: go(n,s,e) actual=%b expected=no cross overlap",
                             {go_n, go_s, go_e});
                end
                g = {go_n, go_s, go_e};
                for (int d = 0; d < 3; d++) begin
                    if (present[d] != 0 && !g[2-d]) waitc[d]++;
                    else waitc[d] = 0;
                    if (waitc[d] > WAIT_MAX) begin
                        errors++;
                        checks++;
                        $display("FAIL R12: dir %0d wait actual=%0d expected<=%0d",
                                 d, waitc[d], WAIT_MAX);
                        waitc[d] = 0;
                    end
                end
            end
            checks++;
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule